// File: doc/BRIEF.md
# Physical Memory Attribute Checker

This block holds a table of memory attribute entries. Each entry describes one naturally aligned physical region: its base, its size as a power of two, the access permissions, the memory type, the atomic class it supports, one dual-meaning cache/combine bit and a coherent-routing bit. Entries are written and read through a simple CSR-style port. Every write is checked for legality. An illegal value is still stored, but it leaves a sticky per-entry error flag and a one-cycle error pulse.

A lookup path takes a physical address and an access kind. One cycle later it returns whether any entry covers the address, which entry won, that entry's decoded attributes, and whether the access must fault. Overlapping entries are resolved in favour of the lowest index.

Top module: `pma_checker`

## Requirements
- R1: The table has 32 entries of 64 bits, all zero after reset. Entry i is written and read at CSR address 0x7E0 + i, and `csr_rdata` returns the stored word in the cycle the address is presented.
- R2: Bits 63:58 hold the log2 region size and bits 51:12 the base. A nonzero entry is illegal when any of bits 11:9 or 57:56 is set, when its size field is below 12, or when its base has a set bit below the size boundary. An all-zero entry is legal. Every write stores the value unchanged.
- R3: In the cycle after an illegal write, `csr_wr_err` is 1 for exactly one cycle and error flag i (bit i of `err_flags`) is set. The flag stays set through later writes to that entry, legal or not.
- R4: A write to CSR address 0x800 clears each error flag whose bit in the write data is 1, and changes no entry. Reading 0x800 returns the error flags in the low 32 bits.
- R5: An entry covers an address when its size field s is nonzero and the address equals the base with the low s bits ignored. An entry with size field 0 never matches.
- R6: When several entries cover an address, the lowest-numbered entry is reported.
- R7: When no entry covers the address, `rsp_hit` is 0, `rsp_fault` is 1, and the index and attribute outputs are 0.
- R8: Access kinds are encoded as read 0, write 1 and execute 2. Each faults when permission bit 0, 1 or 2 of the matched entry is clear. Kind codes 3 and 4 are reserved and always fault.
- R9: Atomic kinds are encoded as swap 5, logical 6 and arithmetic 7. The entry's class in bits 6:5 (0 none, 1 swap, 2 logical, 3 arithmetic) allows an atomic only when the access class (kind bits 1:0) is no higher than the entry class.
- R10: On a hit, `rsp_mtype` is entry bits 4:3, `rsp_cache_comb` is bit 7 (cacheable for main memory, combining for IO), and `rsp_coherent` is bit 8.
- R11: A lookup presented with `lk_valid` appears on the response outputs one cycle later with `rsp_valid` 1. Without a request, `rsp_valid` is 0 and the other response outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | 64 | CSR write data |
| csr_rdata | output | 64 | CSR read data for `csr_addr` |
| csr_wr_err | output | 1 | One-cycle pulse after an illegal entry write |
| err_flags | output | 32 | Sticky per-entry error flags |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 52 | Physical address to check |
| lk_kind | input | 3 | Access kind code |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Some entry covers the address |
| rsp_idx | output | 5 | Index of the winning entry |
| rsp_mtype | output | 2 | Memory type of the winning entry |
| rsp_cache_comb | output | 1 | Cacheable / combining bit |
| rsp_coherent | output | 1 | Coherent routing bit |
| rsp_fault | output | 1 | Access must fault |

## Verification
The bench probes addresses one past the end of a small region that lies inside a larger one. A region mask that is off by one bit would report the small entry instead of the large one. It places the more specific region at a lower index than the large region that contains it, so a reversed priority encoder returns the wrong index. Atomic requests one class above and at the entry's class catch a comparison with the wrong sense. A size-0 entry with permissions set, a size-below-minimum write, a reserved-bit write and a misaligned base show whether the legality check and the invalid-entry rule are wired correctly. A selective clear that must leave the other flags set exposes a clear that wipes every flag.

// File: rtl/pma_pkg.sv
package pma_pkg;
  localparam int ENTRY_W  = 64;
  localparam int PADDR_W  = 52;
  localparam int BASE_LSB = 12;
  localparam int SIZE_LSB = 58;
  localparam int MIN_LOG2 = 12;

  typedef enum logic [2:0] {
    ACC_RD        = 3'd0,
    ACC_WR        = 3'd1,
    ACC_EX        = 3'd2,
    ACC_AMO_SWAP  = 3'd5,
    ACC_AMO_LOGIC = 3'd6,
    ACC_AMO_ARITH = 3'd7
  } acc_kind_e;

  function automatic logic [5:0] size_log2(input logic [ENTRY_W-1:0] e);
    return e[ENTRY_W-1:SIZE_LSB];
  endfunction

  // Bits kept when comparing: everything at or above the size boundary.
  function automatic logic [PADDR_W-1:0] keep_mask(input logic [5:0] s);
    if (int'(s) >= PADDR_W) return '0;
    return ~((PADDR_W'(1) << s) - PADDR_W'(1));
  endfunction

  function automatic logic [PADDR_W-1:0] base_of(input logic [ENTRY_W-1:0] e);
    return {e[PADDR_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
  endfunction

  function automatic logic entry_legal(input logic [ENTRY_W-1:0] e);
    logic [5:0] s;
    s = size_log2(e);
    if (e == '0) return 1'b1;
    if (e[11:9] != '0 || e[57:56] != '0) return 1'b0;
    if (int'(s) < MIN_LOG2) return 1'b0;
    if ((base_of(e) & ~keep_mask(s)) != '0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic entry_hits(input logic [ENTRY_W-1:0] e,
                                      input logic [PADDR_W-1:0] a);
    logic [PADDR_W-1:0] m;
    m = keep_mask(size_log2(e));
    return (size_log2(e) != '0) && ((a & m) == (base_of(e) & m));
  endfunction

  function automatic logic access_fault(input logic [ENTRY_W-1:0] e,
                                        input logic [2:0] kind);
    case (kind)
      ACC_RD:  return !e[0];
      ACC_WR:  return !e[1];
      ACC_EX:  return !e[2];
      ACC_AMO_SWAP, ACC_AMO_LOGIC, ACC_AMO_ARITH:
               return kind[1:0] > e[6:5];
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/pma_entry_table.sv
module pma_entry_table
  import pma_pkg::*;
#(
  parameter int N      = 32,
  parameter int AW     = 12,
  parameter int BASE   = 12'h7E0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     csr_we,
  input  logic [AW-1:0]            csr_addr,
  input  logic [ENTRY_W-1:0]       csr_wdata,
  output logic [ENTRY_W-1:0]       csr_rdata,
  output logic [N-1:0][ENTRY_W-1:0] entries,
  output logic [N-1:0]             err_flags,
  output logic                     wr_err,
  output logic                     wr_illegal
);
  localparam int IW       = $clog2(N);
  localparam int CLR_ADDR = BASE + N;

  logic [AW-1:0] offset;
  logic [IW-1:0] widx;
  logic          in_range, wr_entry, wr_clear;

  assign offset     = csr_addr - AW'(BASE);
  assign widx       = offset[IW-1:0];
  assign in_range   = (csr_addr >= AW'(BASE)) && (csr_addr < AW'(CLR_ADDR));
  assign wr_entry   = csr_we && in_range;
  assign wr_clear   = csr_we && (csr_addr == AW'(CLR_ADDR));
  assign wr_illegal = wr_entry && !entry_legal(csr_wdata);

  for (genvar i = 0; i < N; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entries[i]   <= '0;
        err_flags[i] <= 1'b0;
      end else begin
        if (wr_entry && widx == IW'(i)) entries[i] <= csr_wdata;
        if (wr_illegal && widx == IW'(i)) err_flags[i] <= 1'b1;
        else if (wr_clear && csr_wdata[i]) err_flags[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wr_err <= 1'b0;
    else        wr_err <= wr_illegal;
  end

  always_comb begin
    if (in_range)                       csr_rdata = entries[widx];
    else if (csr_addr == AW'(CLR_ADDR)) csr_rdata = ENTRY_W'(err_flags);
    else                                csr_rdata = '0;
  end
endmodule

// File: rtl/pma_match.sv
module pma_match
  import pma_pkg::*;
#(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0][ENTRY_W-1:0] entries,
  input  logic [PADDR_W-1:0]        addr,
  output logic                      hit,
  output logic [IW-1:0]             idx
);
  logic [N-1:0] hit_vec;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = entry_hits(entries[i], addr);
  end

  // Scan from the top so the lowest set index is written last.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx = IW'(i);
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/pma_resp_reg.sv
module pma_resp_reg
  import pma_pkg::*;
#(
  parameter int IW = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [2:0]         lk_kind,
  input  logic               m_hit,
  input  logic [IW-1:0]      m_idx,
  input  logic [ENTRY_W-1:0] m_entry,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [IW-1:0]      rsp_idx,
  output logic [1:0]         rsp_mtype,
  output logic               rsp_cache_comb,
  output logic               rsp_coherent,
  output logic               rsp_fault
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_idx        <= '0;
      rsp_mtype      <= '0;
      rsp_cache_comb <= 1'b0;
      rsp_coherent   <= 1'b0;
      rsp_fault      <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_hit        <= m_hit;
        rsp_idx        <= m_hit ? m_idx : '0;
        rsp_mtype      <= m_hit ? m_entry[4:3] : 2'b00;
        rsp_cache_comb <= m_hit && m_entry[7];
        rsp_coherent   <= m_hit && m_entry[8];
        rsp_fault      <= !m_hit || access_fault(m_entry, lk_kind);
      end
    end
  end
endmodule

// File: rtl/pma_checker.sv
module pma_checker
  import pma_pkg::*;
#(
  parameter int N         = 32,
  parameter int AW        = 12,
  parameter int CSR_BASE  = 12'h7E0,
  localparam int IW       = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_we,
  input  logic [AW-1:0]      csr_addr,
  input  logic [63:0]        csr_wdata,
  output logic [63:0]        csr_rdata,
  output logic               csr_wr_err,
  output logic [N-1:0]       err_flags,
  input  logic               lk_valid,
  input  logic [51:0]        lk_addr,
  input  logic [2:0]         lk_kind,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [IW-1:0]      rsp_idx,
  output logic [1:0]         rsp_mtype,
  output logic               rsp_cache_comb,
  output logic               rsp_coherent,
  output logic               rsp_fault
);
  logic [N-1:0][ENTRY_W-1:0] entries;
  logic                      wr_illegal;
  logic                      m_hit;
  logic [IW-1:0]             m_idx;
  logic [ENTRY_W-1:0]        m_entry;

  pma_entry_table #(.N(N), .AW(AW), .BASE(CSR_BASE)) u_table (
    .clk, .rst_n, .csr_we, .csr_addr, .csr_wdata, .csr_rdata,
    .entries, .err_flags, .wr_err(csr_wr_err), .wr_illegal
  );

  pma_match #(.N(N), .IW(IW)) u_match (
    .entries, .addr(lk_addr), .hit(m_hit), .idx(m_idx)
  );

  assign m_entry = entries[m_idx];

  pma_resp_reg #(.IW(IW)) u_resp (
    .clk, .rst_n, .lk_valid, .lk_kind, .m_hit, .m_idx, .m_entry,
    .rsp_valid, .rsp_hit, .rsp_idx, .rsp_mtype, .rsp_cache_comb,
    .rsp_coherent, .rsp_fault
  );
endmodule

// File: rtl/pma_checker_sva.sv
module pma_checker_sva #(
  parameter int N    = 32,
  parameter int AW   = 12,
  parameter int BASE = 12'h7E0,
  localparam int IW  = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          csr_we,
  input logic [AW-1:0] csr_addr,
  input logic          csr_wr_err,
  input logic [N-1:0]  err_flags,
  input logic          wr_illegal,
  input logic          lk_valid,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic [IW-1:0] rsp_idx,
  input logic          rsp_fault
);
  logic [AW-1:0] off;
  assign off = csr_addr - AW'(BASE);

  assert_err_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr_err |-> $past(csr_we && csr_addr >= AW'(BASE) && csr_addr < AW'(BASE + N)));

  assert_err_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_illegal |=> (csr_wr_err && err_flags[$past(off[IW-1:0])]));

  assert_flags_rise_on_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_flags & ~$past(err_flags)) != '0) |-> csr_wr_err);

  assert_miss_faults_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_fault && rsp_idx == '0));

  assert_rsp_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!rsp_valid && $stable(rsp_hit) && $stable(rsp_idx) && $stable(rsp_fault)));
endmodule

bind pma_checker pma_checker_sva #(.N(N), .AW(AW), .BASE(CSR_BASE)) u_sva (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
  .csr_wr_err(csr_wr_err), .err_flags(err_flags), .wr_illegal(wr_illegal),
  .lk_valid(lk_valid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_idx(rsp_idx), .rsp_fault(rsp_fault)
);

// File: tb/pma_checker_test.sv
module pma_checker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        csr_wr_err;
  logic [31:0] err_flags;
  logic        lk_valid = 1'b0;
  logic [51:0] lk_addr = '0;
  logic [2:0]  lk_kind = '0;
  logic        rsp_valid, rsp_hit, rsp_cache_comb, rsp_coherent, rsp_fault;
  logic [4:0]  rsp_idx;
  logic [1:0]  rsp_mtype;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic pulse_seen;

  always #10 clk = ~clk;

  pma_checker uut (
    .clk, .rst_n, .csr_we, .csr_addr, .csr_wdata, .csr_rdata, .csr_wr_err,
    .err_flags, .lk_valid, .lk_addr, .lk_kind, .rsp_valid, .rsp_hit,
    .rsp_idx, .rsp_mtype, .rsp_cache_comb, .rsp_coherent, .rsp_fault
  );

  typedef struct packed {
    logic [51:0] addr;
    logic [2:0]  kind;
    logic        hit;
    logic [4:0]  idx;
    logic        fault;
    logic [1:0]  mtype;
    logic        cc;
    logic        coh;
  } vec_t;

  // Entries: 0 = 4KB @0x9000_0000 X-only io-ordered-1 logical coherent
  //          1 = 64KB @0x1000_0000 RW io-relaxed swap combining
  //          3 = 2GB @0x8000_0000 RWX main arith cacheable coherent
  //         31 = size 0 (invalid) @0x2000_0000 RWX
  localparam vec_t VECS [12] = '{
    '{52'h0_9000_0123, 3'd2, 1'b1, 5'd0, 1'b0, 2'd3, 1'b0, 1'b1}, // R8 exec ok
    '{52'h0_9000_0123, 3'd0, 1'b1, 5'd0, 1'b1, 2'd3, 1'b0, 1'b1}, // R8 read denied
    '{52'h0_9000_1000, 3'd0, 1'b1, 5'd3, 1'b0, 2'd0, 1'b1, 1'b1}, // R5 R6 past small region
    '{52'h0_9000_0800, 3'd6, 1'b1, 5'd0, 1'b0, 2'd3, 1'b0, 1'b1}, // R9 equal class
    '{52'h0_9000_0800, 3'd7, 1'b1, 5'd0, 1'b1, 2'd3, 1'b0, 1'b1}, // R9 higher class
    '{52'h0_1000_FFFF, 3'd1, 1'b1, 5'd1, 1'b0, 2'd1, 1'b1, 1'b0}, // R5 R10 last byte
    '{52'h0_1001_0000, 3'd0, 1'b0, 5'd0, 1'b1, 2'd0, 1'b0, 1'b0}, // R7 miss
    '{52'h0_1000_0040, 3'd5, 1'b1, 5'd1, 1'b0, 2'd1, 1'b1, 1'b0}, // R9 swap ok
    '{52'h0_1000_0040, 3'd6, 1'b1, 5'd1, 1'b1, 2'd1, 1'b1, 1'b0}, // R9 logical denied
    '{52'h0_2000_0000, 3'd0, 1'b0, 5'd0, 1'b1, 2'd0, 1'b0, 1'b0}, // R5 size 0 no match
    '{52'h0_FFFF_FFFF, 3'd2, 1'b1, 5'd3, 1'b0, 2'd0, 1'b1, 1'b1}, // R10 top of big region
    '{52'h0_8000_0000, 3'd3, 1'b1, 5'd3, 1'b1, 2'd0, 1'b1, 1'b1}  // R8 reserved kind
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    pulse_seen = csr_wr_err;
    csr_we = 1'b0;
  endtask

  task automatic lookup(input logic [51:0] a, input logic [2:0] k);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_kind = k;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    csr_addr = 12'h7E0; #1;
    check("R1 reset entry0", csr_rdata, 64'h0);
    csr_addr = 12'h7FF; #1;
    check("R1 reset entry31", csr_rdata, 64'h0);
    check("R3 reset flags", 64'(err_flags), 64'h0);
    check("R11 reset rsp_valid", 64'(rsp_valid), 64'h0);

    csr_write(12'h7E0, 64'h3000_0000_9000_015C);
    check("R3 legal write no pulse", 64'(pulse_seen), 64'h0);
    csr_write(12'h7E1, 64'h4000_0000_1000_00AB);
    csr_write(12'h7E3, 64'h7C00_0000_8000_01E7);
    check("R1 readback entry3", csr_rdata, 64'h7C00_0000_8000_01E7);
    check("R3 legal writes leave flags", 64'(err_flags), 64'h0);
    csr_write(12'h7FF, 64'h0000_0000_2000_0007);
    check("R2 small size illegal pulse", 64'(pulse_seen), 64'h1);
    check("R2 illegal value stored", csr_rdata, 64'h0000_0000_2000_0007);
    @(negedge clk);
    check("R3 pulse one cycle", 64'(csr_wr_err), 64'h0);
    check("R3 flag31 set", 64'(err_flags), 64'h8000_0000);

    for (int i = 0; i < 12; i++) begin
      lookup(VECS[i].addr, VECS[i].kind);
      check($sformatf("R11 vec%0d valid", i), 64'(rsp_valid), 64'h1);
      check($sformatf("R5 R6 R7 vec%0d hit", i), 64'(rsp_hit), 64'(VECS[i].hit));
      check($sformatf("R6 vec%0d idx", i), 64'(rsp_idx), 64'(VECS[i].idx));
      check($sformatf("R8 R9 vec%0d fault", i), 64'(rsp_fault), 64'(VECS[i].fault));
      check($sformatf("R10 vec%0d attrs", i),
            64'({rsp_mtype, rsp_cache_comb, rsp_coherent}),
            64'({VECS[i].mtype, VECS[i].cc, VECS[i].coh}));
    end

    // R11 hold without request: last result was vec11
    @(negedge clk);
    lk_addr = 52'h0_1001_0000; lk_kind = 3'd0;
    @(negedge clk);
    check("R11 no request valid low", 64'(rsp_valid), 64'h0);
    check("R11 hold hit/idx/fault", 64'({rsp_hit, rsp_idx, rsp_fault}), 64'({1'b1, 5'd3, 1'b1}));

    // R2 more illegal encodings, and a legal zero write
    csr_write(12'h7E5, 64'h3000_0000_9000_0200);
    check("R2 reserved bit illegal", 64'(pulse_seen), 64'h1);
    csr_write(12'h7E6, 64'h4000_0000_1000_1000);
    check("R2 misaligned base illegal", 64'(pulse_seen), 64'h1);
    csr_write(12'h7E7, 64'h0);
    check("R2 zero entry legal", 64'(pulse_seen), 64'h0);
    csr_write(12'h7E5, 64'h3000_0000_9000_0000);
    check("R3 legal rewrite keeps flag", 64'(err_flags), 64'h8000_0060);

    // R4 selective clear
    csr_write(12'h800, 64'h20);
    check("R4 clear bit5 only", 64'(err_flags), 64'h8000_0040);
    csr_addr = 12'h800; #1;
    check("R4 read flags", csr_rdata, 64'h8000_0040);
    csr_addr = 12'h7E3; #1;
    check("R4 clear leaves entries", csr_rdata, 64'h7C00_0000_8000_01E7);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule